// File: doc/BRIEF.md
# Micro-TLB with selective invalidation

A small, fully associative translation cache held in flip-flops. It sits in front of a larger main TLB and keeps recently used translations close to the pipeline. A lookup presents a virtual page number, the current address-space ID, the privilege mode and the access type. In the same cycle the block returns hit, the physical frame number and a protection-fault flag. On a miss it raises a refill request. The main TLB answers with a fill, and the block installs it.

The cache is deliberately not inclusive of the main TLB. When the main array overwrites a victim during its own refill, it issues a write flagged "keep", and the entries held here survive. Only a plain main-TLB write or an explicit flush command clears the whole array. This lets the high associativity here hide the low associativity of the main array. The way count is a parameter: 8 for a data-side instance and 4 for an instruction-side instance.

Top module: `utlb_cache`

## Requirements
- R1: A lookup hits when a valid entry has the same page number and either the same address-space ID or its global flag set. On a hit, `lu_hit`=1 and `lu_pfn` carries that entry's frame number in the same cycle. When `lu_valid`=0, both `lu_hit` and `refill_req` are 0.
- R2: A lookup with `lu_valid`=1 that matches no entry gives `lu_hit`=0 and `refill_req`=1 in the same cycle.
- R3: When `fill_valid`=1 in a cycle with no clear, the entry is installed at that clock edge. A lookup of that tag hits from the next cycle on.
- R4: The stored permissions are six bits. Bits [2:0] are the kernel read/write/execute bits (bit 2 = read, bit 1 = write, bit 0 = execute), and bits [5:3] are the user bits in the same order. A global fill stores `{3'b000, fill_rwx}`. A non-global fill stores `{fill_rwx, fill_rwx}`.
- R5: On a hit, `lu_fault`=1 when the permission bit for the access is clear. The kernel bits apply when `lu_user`=0 and the user bits when it is 1. The access codes are 0 = load (read bit), 1 = store (write bit) and 2 = fetch (execute bit); code 3 always faults. On a miss, `lu_fault`=0.
- R6: `flush_cmd`=1, or `mtlb_wr`=1 with `mtlb_wr_keep`=0, invalidates every entry at that clock edge and returns the replacement pointer to way 0.
- R7: `mtlb_wr`=1 with `mtlb_wr_keep`=1 leaves every entry intact.
- R8: A fill with a new tag goes into the lowest-numbered empty way. When every way is valid, it replaces the way under a round-robin pointer. That pointer then advances by one and wraps after the last way.
- R9: A clear in the same cycle as a fill wins, and the filled entry is not kept.
- R10: A fill whose tag already hits (by the R1 rule) rewrites that way in place. It evicts nothing and leaves the round-robin pointer unchanged.
- R11: After reset, all entries are invalid and the round-robin pointer is at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lu_valid | input | 1 | Lookup request |
| lu_vpn | input | VPN_W | Lookup virtual page number |
| lu_asid | input | ASID_W | Current address-space ID |
| lu_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lu_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lu_hit | output | 1 | Lookup hit |
| lu_pfn | output | PFN_W | Frame number of the hit entry, 0 on a miss |
| lu_fault | output | 1 | Permission violation on a hit |
| refill_req | output | 1 | Lookup missed, refill from the main TLB wanted |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VPN_W | Refill page number |
| fill_asid | input | ASID_W | Refill address-space ID |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_glob | input | 1 | Refill entry is global |
| fill_rwx | input | 3 | Refill read/write/execute bits |
| mtlb_wr | input | 1 | Main TLB was written |
| mtlb_wr_keep | input | 1 | That main-TLB write must not disturb this cache |
| flush_cmd | input | 1 | Explicit invalidate-all command |

## Verification
The single-match assertion assumes that at most one way matches any tag. That holds only if a given page number is used either always as global or always as non-global, because a global and a non-global entry with the same page number could both match. The stimulus keeps to this by deriving globalness from bit 3 of the page number in every fill and lookup. Non-global fills are then unique per page-number and ID pair, and global fills collapse onto their page number through the in-place rewrite. Fill and clear inputs are drawn freely, including collisions of fill with flush or a plain write, so the clear-wins ordering and the keep-write case both occur often.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    parameter int VPN_W  = 20;
    parameter int PFN_W  = 20;
    parameter int ASID_W = 8;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [5:0]        perm;   // [5:3] user rwx, [2:0] kernel rwx
    } ent_t;

    // Global pages are kernel only; private pages mirror kernel into user.
    function automatic logic [5:0] expand_perm(logic glob, logic [2:0] rwx);
        return glob ? {3'b000, rwx} : {rwx, rwx};
    endfunction

    function automatic logic perm_ok(logic [5:0] perm, logic user, acc_e acc);
        logic [2:0] sel;
        sel = user ? perm[5:3] : perm[2:0];
        case (acc)
            ACC_LOAD:  return sel[2];
            ACC_STORE: return sel[1];
            ACC_FETCH: return sel[0];
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic tag_hit(ent_t e, logic [VPN_W-1:0] vpn,
                                     logic [ASID_W-1:0] asid);
        return e.vld && (e.vpn == vpn) && (e.glob || (e.asid == asid));
    endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  ent_t [WAYS-1:0]   ents,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [WAYS-1:0]   hit_vec,
    output logic [PFN_W-1:0]  pfn,
    output logic [5:0]        perm
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = tag_hit(ents[w], vpn, asid);
    end

    // OR-mux: at most one way matches, so OR-ing the selected fields is exact.
    always_comb begin
        pfn  = '0;
        perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                pfn  = pfn | ents[w].pfn;
                perm = perm | ents[w].perm;
            end
        end
    end

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter  int WAYS  = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld_vec,
    input  logic [WAYS-1:0]  dup_vec,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] slot,
    output logic             adv
);

    // Priority: rewrite matching way, else lowest empty way, else round-robin.
    always_comb begin
        logic found;
        found = 1'b0;
        slot  = rr;
        adv   = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && dup_vec[w]) begin
                found = 1'b1;
                slot  = IDX_W'(w);
                adv   = 1'b0;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !vld_vec[w]) begin
                found = 1'b1;
                slot  = IDX_W'(w);
                adv   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
    import utlb_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lu_valid,
    input  logic [VPN_W-1:0]  lu_vpn,
    input  logic [ASID_W-1:0] lu_asid,
    input  logic              lu_user,
    input  logic [1:0]        lu_acc,
    output logic              lu_hit,
    output logic [PFN_W-1:0]  lu_pfn,
    output logic              lu_fault,
    output logic              refill_req,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_glob,
    input  logic [2:0]        fill_rwx,
    input  logic              mtlb_wr,
    input  logic              mtlb_wr_keep,
    input  logic              flush_cmd
);

    localparam int IDX_W = $clog2(WAYS);

    ent_t [WAYS-1:0]  ents;
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] slot;
    logic             adv;
    logic [WAYS-1:0]  vld_vec;
    logic [WAYS-1:0]  dup_vec;
    logic [WAYS-1:0]  hit_vec;
    logic [PFN_W-1:0] m_pfn;
    logic [5:0]       m_perm;
    logic             clr;
    logic             any_hit;
    ent_t             new_ent;

    assign clr = flush_cmd | (mtlb_wr & ~mtlb_wr_keep);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign vld_vec[w] = ents[w].vld;
        assign dup_vec[w] = tag_hit(ents[w], fill_vpn, fill_asid);
    end

    utlb_match #(.WAYS(WAYS)) u_match (
        .ents    (ents),
        .vpn     (lu_vpn),
        .asid    (lu_asid),
        .hit_vec (hit_vec),
        .pfn     (m_pfn),
        .perm    (m_perm)
    );

    utlb_victim #(.WAYS(WAYS)) u_victim (
        .vld_vec (vld_vec),
        .dup_vec (dup_vec),
        .rr      (rr_q),
        .slot    (slot),
        .adv     (adv)
    );

    always_comb begin
        new_ent      = '0;
        new_ent.vld  = 1'b1;
        new_ent.glob = fill_glob;
        new_ent.asid = fill_asid;
        new_ent.vpn  = fill_vpn;
        new_ent.pfn  = fill_pfn;
        new_ent.perm = expand_perm(fill_glob, fill_rwx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
            rr_q <= '0;
        end else if (clr) begin
            for (int w = 0; w < WAYS; w++) ents[w].vld <= 1'b0;
            rr_q <= '0;
        end else if (fill_valid) begin
            ents[slot] <= new_ent;
            if (adv) rr_q <= (rr_q == IDX_W'(WAYS - 1)) ? '0 : rr_q + IDX_W'(1);
        end
    end

    assign any_hit    = |hit_vec;
    assign lu_hit     = lu_valid & any_hit;
    assign refill_req = lu_valid & ~any_hit;
    assign lu_pfn     = m_pfn;
    assign lu_fault   = lu_hit & ~perm_ok(m_perm, lu_user, acc_e'(lu_acc));

    // R1: a tag never matches more than one way
    assert_single_hit_R1: assert property (@(posedge clk) disable iff (rst)
        lu_valid |-> $onehot0(hit_vec));

    // R3: an unblocked fill leaves at least one valid way
    assert_fill_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !clr) |=> (vld_vec != '0));

    // R6, R9: any clear empties the array, fill or not
    assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vld_vec == '0));

    // R7: a keep-write alone leaves occupancy untouched
    assert_keep_write_R7: assert property (@(posedge clk) disable iff (rst)
        (mtlb_wr && mtlb_wr_keep && !flush_cmd && !fill_valid) |=> $stable(vld_vec));

    // R8: pointer only moves when the array was already full
    assert_rr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !clr && !(&vld_vec)) |=> $stable(rr_q));

endmodule

// File: tb/tb_utlb_cache.sv
`timescale 1ns/1ps
module tb_utlb_cache;
    import utlb_pkg::*;

    localparam int W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lu_valid = 0;
    logic [VPN_W-1:0]  lu_vpn = '0;
    logic [ASID_W-1:0] lu_asid = '0;
    logic              lu_user = 0;
    logic [1:0]        lu_acc = '0;
    logic              lu_hit;
    logic [PFN_W-1:0]  lu_pfn;
    logic              lu_fault;
    logic              refill_req;
    logic              fill_valid = 0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic              fill_glob = 0;
    logic [2:0]        fill_rwx = '0;
    logic              mtlb_wr = 0;
    logic              mtlb_wr_keep = 0;
    logic              flush_cmd = 0;

    always #2.5 clk = ~clk;

    utlb_cache #(.WAYS(W)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // expected-state model
    logic              m_vld [W];
    logic              m_glob[W];
    logic [ASID_W-1:0] m_asid[W];
    logic [VPN_W-1:0]  m_vpn [W];
    logic [PFN_W-1:0]  m_pfn [W];
    logic [5:0]        m_perm[W];
    int                m_rr;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] want_perm(logic g, logic [2:0] rwx);
        if (g) return {3'b000, rwx};
        return {rwx, rwx};
    endfunction

    function automatic logic allowed(logic [5:0] pm, logic usr, logic [1:0] acc);
        int base;
        base = usr ? 3 : 0;
        case (acc)
            2'd0: return pm[base + 2];
            2'd1: return pm[base + 1];
            2'd2: return pm[base];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int find_tag(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
        for (int i = 0; i < W; i++)
            if (m_vld[i] && m_vpn[i] == v && (m_glob[i] || m_asid[i] == a)) return i;
        return -1;
    endfunction

    task automatic check_outputs();
        int k;
        if (!lu_valid) begin
            chk("R1", "idle hit", lu_hit, 0);
            chk("R1", "idle refill", refill_req, 0);
        end else begin
            k = find_tag(lu_vpn, lu_asid);
            chk("R1", "hit", lu_hit, k >= 0);
            chk("R2", "refill_req", refill_req, k < 0);
            if (k >= 0) begin
                chk("R1", "pfn", lu_pfn, m_pfn[k]);
                chk("R5", "fault", lu_fault, !allowed(m_perm[k], lu_user, lu_acc));
            end else begin
                chk("R5", "fault on miss", lu_fault, 0);
            end
        end
    endtask

    task automatic model_update();
        int s;
        if (rst || flush_cmd || (mtlb_wr && !mtlb_wr_keep)) begin
            for (int i = 0; i < W; i++) m_vld[i] = 1'b0;
            m_rr = 0;
        end else if (fill_valid) begin
            s = find_tag(fill_vpn, fill_asid);
            if (s < 0)
                for (int i = 0; i < W; i++) if (s < 0 && !m_vld[i]) s = i;
            if (s < 0) begin
                s    = m_rr;
                m_rr = (m_rr + 1) % W;
            end
            m_vld[s]  = 1'b1;
            m_glob[s] = fill_glob;
            m_asid[s] = fill_asid;
            m_vpn[s]  = fill_vpn;
            m_pfn[s]  = fill_pfn;
            m_perm[s] = want_perm(fill_glob, fill_rwx);
        end
    endtask

    task automatic fin();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic tick();
        #1 check_outputs();
        fin();
    endtask

    task automatic quiet();
        lu_valid = 0; fill_valid = 0; mtlb_wr = 0; mtlb_wr_keep = 0; flush_cmd = 0;
    endtask

    // globalness follows bit 3 of the page number (keeps tags unambiguous)
    task automatic fill(int v, int a, int p, logic [2:0] rwx);
        quiet();
        fill_valid = 1; fill_vpn = VPN_W'(v); fill_asid = ASID_W'(a);
        fill_pfn = PFN_W'(p); fill_glob = (v & 8) != 0; fill_rwx = rwx;
        tick();
        quiet();
    endtask

    task automatic look(int v, int a, logic usr, int acc);
        quiet();
        lu_valid = 1; lu_vpn = VPN_W'(v); lu_asid = ASID_W'(a);
        lu_user = usr; lu_acc = 2'(acc);
        #1 check_outputs();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < W; i++) m_vld[i] = 1'b0;
        m_rr = 0;
        quiet();
        @(negedge clk);
        fin(); fin();
        rst = 0;

        // R11: empty after reset
        look(5, 1, 0, 0);
        chk("R11", "hit after reset", lu_hit, 0);
        chk("R11", "refill after reset", refill_req, 1);
        fin();

        // R3, R1, R2
        fill(5, 1, 'hA5, 3'b110);
        look(5, 1, 0, 0);
        chk("R3", "hit after fill", lu_hit, 1);
        chk("R3", "pfn after fill", lu_pfn, 'hA5);
        fin();
        look(5, 2, 0, 0);
        chk("R2", "other asid misses", refill_req, 1);
        fin();
        // R5: perms {110,110}
        look(5, 1, 1, 1);
        chk("R5", "user store allowed", lu_fault, 0);
        fin();
        look(5, 1, 1, 2);
        chk("R5", "user fetch denied", lu_fault, 1);
        fin();
        look(5, 1, 0, 3);
        chk("R5", "reserved code faults", lu_fault, 1);
        fin();

        // R4: global page, kernel only
        fill(12, 0, 'h3C, 3'b111);
        look(12, 3, 0, 2);
        chk("R1", "global any asid hit", lu_hit, 1);
        chk("R4", "global kernel fetch", lu_fault, 0);
        fin();
        look(12, 3, 1, 0);
        chk("R4", "global user read denied", lu_fault, 1);
        fin();

        // R7 then R6
        quiet(); mtlb_wr = 1; mtlb_wr_keep = 1; tick(); quiet();
        look(5, 1, 0, 0);
        chk("R7", "keep-write retains", lu_hit, 1);
        fin();
        quiet(); mtlb_wr = 1; tick(); quiet();
        look(5, 1, 0, 0);
        chk("R6", "plain write clears", lu_hit, 0);
        fin();
        fill(5, 1, 'h11, 3'b100);
        quiet(); flush_cmd = 1; tick(); quiet();
        look(5, 1, 0, 0);
        chk("R6", "flush clears", lu_hit, 0);
        fin();

        // R9: clear wins over same-cycle fill
        quiet();
        fill_valid = 1; fill_vpn = 7; fill_asid = 1; fill_pfn = 'h99; fill_glob = 0;
        fill_rwx = 3'b111; flush_cmd = 1;
        tick(); quiet();
        look(7, 1, 0, 0);
        chk("R9", "fill dropped under flush", lu_hit, 0);
        fin();

        // R8: fill empties in order, then round-robin from way 0
        for (int i = 0; i < W; i++) fill(i, 1, 100 + i, 3'b111);
        fill(16, 1, 'h200, 3'b111);
        look(0, 1, 0, 0);
        chk("R8", "way0 evicted first", lu_hit, 0);
        fin();
        look(1, 1, 0, 0);
        chk("R8", "way1 kept", lu_hit, 1);
        fin();
        fill(17, 1, 'h201, 3'b111);
        look(1, 1, 0, 0);
        chk("R8", "way1 evicted second", lu_hit, 0);
        fin();

        // R10: rewrite in place, pointer unchanged
        fill(2, 1, 'h77, 3'b101);
        look(2, 1, 0, 0);
        chk("R10", "rewritten pfn", lu_pfn, 'h77);
        fin();
        look(3, 1, 0, 0);
        chk("R10", "no eviction", lu_hit, 1);
        fin();
        fill(18, 1, 'h202, 3'b111);
        look(2, 1, 0, 0);
        chk("R10", "pointer still at way2", lu_hit, 0);
        fin();

        // random mix
        for (int n = 0; n < 6000; n++) begin
            int r;
            quiet();
            lu_valid  = ($urandom % 4) != 0;
            lu_vpn    = VPN_W'($urandom % 32);
            lu_asid   = ASID_W'($urandom % 4);
            lu_user   = $urandom % 2;
            lu_acc    = 2'($urandom % 4);
            fill_valid = ($urandom % 3) == 0;
            fill_vpn  = VPN_W'($urandom % 32);
            fill_asid = ASID_W'($urandom % 4);
            fill_glob = fill_vpn[3];
            fill_pfn  = PFN_W'($urandom);
            fill_rwx  = 3'($urandom % 8);
            r = $urandom % 100;
            if (r < 2) flush_cmd = 1;
            else if (r < 6) begin mtlb_wr = 1; mtlb_wr_keep = $urandom % 2; end
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule